// File: doc/BRIEF.md
# Framed Serial Result Transmitter

This block sends a 14-bit two's complement conversion result over a three-wire serial link. The link has a serial clock, an active-low framing strobe and a data line, and each of the three has its own output-enable so that it can be three-stated. The serial clock is made by dividing the converter clock: its level changes every `HALF_CYC` converter-clock cycles. A receiver takes each data bit on a falling serial-clock edge while the strobe is low.

A one-cycle `load` pulse hands over a new result. The result waits in a holding register until the next rising serial-clock edge at which no frame is in progress. At that edge the strobe falls and the first data bit appears. The transmitter sends fourteen bits, MSB first, and moves to the next bit on each rising serial-clock edge. After the fourteenth period the strobe is released. When `cont_mode` is high the serial clock is driven at all times. When it is low the clock is driven only while a frame is in progress.

Top module: `serial_result_tx`

## Requirements
- R1: While reset is high and after it, until a frame starts, `strb_n_o` is 1 and `strb_oe`, `sdata_oe` are 0. `sclk_o` is 0 during reset.
- R2: After reset the serial clock starts low and changes level every `HALF_CYC` clock cycles, so one serial period is 2·`HALF_CYC` cycles.
- R3: A frame starts only on a clock edge where `sclk_o` rises. At that edge the strobe goes low and is driven, and the data line carries the MSB. The first falling serial edge is therefore half a period later.
- R4: Bits leave MSB first. `sdata_o` changes only together with a rising `sclk_o` and stays stable through the falling edge.
- R5: The strobe stays low for exactly 14 serial periods (28·`HALF_CYC` cycles), and 14 falling edges occur inside it. The strobe returns high on a rising edge and stays high for at least one full serial period before the next frame.
- R6: `sdata_oe` is 1 exactly while the strobe is driven low. Otherwise the data line is released.
- R7: With `cont_mode`=1, `sclk_oe` is 1 on every cycle.
- R8: With `cont_mode`=0, `sclk_oe` is 1 only while a frame is in progress.
- R9: A result loaded during a frame waits. It goes out on the first rising edge after the frame's closing edge, exactly one serial period after the strobe returned high.
- R10: If several loads arrive before a frame starts, only the most recent result is sent.
- R11: The received 14-bit word equals the loaded two's complement value, including the extremes 0x2000 and 0x1FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| cont_mode | input | 1 | 1: serial clock always driven; 0: gated to frames |
| load | input | 1 | One-cycle pulse, new result valid |
| result | input | 14 | Two's complement result captured on `load` |
| sclk_o | output | 1 | Serial clock level |
| sclk_oe | output | 1 | Serial clock drive enable |
| strb_n_o | output | 1 | Active-low framing strobe level |
| strb_oe | output | 1 | Strobe drive enable |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Serial data drive enable |

## Verification
The bound checker enforces the local timing rules on every cycle. It checks the spacing between serial-clock edges and that the strobe starts and ends only on rising edges. It checks that data changes only with a rising edge, that the strobe stays low for a fixed length, and that the clock enable obeys each mode. Other behaviour depends on the order of loads across frames: whether the bits reassemble into the loaded value, whether a load during a frame is deferred, and whether the latest of several loads wins. Only the bench scenarios can show these. They use a serial receiver in the bench and a cycle-level reference model.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned WORD_BITS = 14;
    localparam int unsigned IDX_BITS  = $clog2(WORD_BITS);

    typedef logic [WORD_BITS-1:0] word_t;
    typedef logic [IDX_BITS-1:0]  idx_t;

    localparam idx_t LAST_IDX = idx_t'(WORD_BITS - 1);

    // one three-state pin: drive enable plus level
    typedef struct packed {
        logic drive;
        logic level;
    } pin_t;

    // state of the frame shifter
    typedef struct packed {
        logic  active;
        idx_t  idx;
        word_t shreg;
    } frame_t;

    function automatic logic word_msb(input word_t w);
        return w[WORD_BITS-1];
    endfunction

    function automatic word_t word_shift(input word_t w);
        return {w[WORD_BITS-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/sertx_clkgen.sv
module sertx_clkgen #(
    parameter int unsigned HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    output logic sclk_lvl,
    output logic rise_evt
);

    logic tick;

    generate
        if (HALF_CYC <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_div
            localparam int unsigned CW = $clog2(HALF_CYC);
            localparam logic [CW-1:0] TOP = CW'(HALF_CYC - 1);
            logic [CW-1:0] ph_cnt;

            assign tick = (ph_cnt == TOP);

            always_ff @(posedge clk) begin
                if (rst || tick) begin
                    ph_cnt <= '0;
                end else begin
                    ph_cnt <= ph_cnt + 1'b1;
                end
            end
        end
    endgenerate

    assign rise_evt = tick && !sclk_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_lvl <= 1'b0;
        end else if (tick) begin
            sclk_lvl <= ~sclk_lvl;
        end
    end

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t result,
    input  logic  take,
    output logic  pending,
    output word_t word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            word    <= '0;
        end else if (load) begin
            // a newer result replaces one not yet started
            pending <= 1'b1;
            word    <= result;
        end else if (take) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rise_evt,
    input  logic   pending,
    input  word_t  word,
    output logic   take,
    output frame_t st
);

    assign take = rise_evt && !st.active && pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (rise_evt) begin
            if (st.active) begin
                if (st.idx == '0) begin
                    st.active <= 1'b0;
                end else begin
                    st.idx   <= st.idx - 1'b1;
                    st.shreg <= word_shift(st.shreg);
                end
            end else if (pending) begin
                st.active <= 1'b1;
                st.idx    <= LAST_IDX;
                st.shreg  <= word;
            end
        end
    end

endmodule

// File: rtl/serial_result_tx.sv
module serial_result_tx
    import sertx_pkg::*;
#(
    parameter int unsigned HALF_CYC = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cont_mode,
    input  logic                 load,
    input  logic [WORD_BITS-1:0] result,
    output logic                 sclk_o,
    output logic                 sclk_oe,
    output logic                 strb_n_o,
    output logic                 strb_oe,
    output logic                 sdata_o,
    output logic                 sdata_oe
);

    logic   sclk_lvl;
    logic   rise_evt;
    logic   pending;
    logic   take;
    word_t  held;
    frame_t st;
    pin_t   p_sclk, p_strb, p_data;

    sertx_clkgen #(.HALF_CYC(HALF_CYC)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .sclk_lvl (sclk_lvl),
        .rise_evt (rise_evt)
    );

    sertx_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .result  (result),
        .take    (take),
        .pending (pending),
        .word    (held)
    );

    sertx_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .rise_evt (rise_evt),
        .pending  (pending),
        .word     (held),
        .take     (take),
        .st       (st)
    );

    always_comb begin
        p_sclk.level = sclk_lvl;
        p_sclk.drive = cont_mode || st.active;
        p_strb.level = !st.active;
        p_strb.drive = st.active;
        p_data.level = st.active && word_msb(st.shreg);
        p_data.drive = st.active;
    end

    assign sclk_o   = p_sclk.level;
    assign sclk_oe  = p_sclk.drive;
    assign strb_n_o = p_strb.level;
    assign strb_oe  = p_strb.drive;
    assign sdata_o  = p_data.level;
    assign sdata_oe = p_data.drive;

endmodule

// File: rtl/sertx_sva.sv
module sertx_sva #(
    parameter int unsigned HALF_CYC = 2
) (
    input logic clk,
    input logic rst,
    input logic cont_mode,
    input logic sclk_o,
    input logic sclk_oe,
    input logic strb_n_o,
    input logic strb_oe,
    input logic sdata_o,
    input logic sdata_oe
);

    localparam int unsigned FRAME_CYC = 28 * HALF_CYC;

    int unsigned low_cnt;
    int unsigned lvl_cnt;
    logic        prev_sclk;
    logic        seen_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt   <= 0;
            lvl_cnt   <= 0;
            prev_sclk <= 1'b0;
            seen_edge <= 1'b0;
        end else begin
            low_cnt   <= strb_n_o ? 0 : low_cnt + 1;
            prev_sclk <= sclk_o;
            if (sclk_o != prev_sclk) begin
                lvl_cnt   <= 1;
                seen_edge <= 1'b1;
            end else if (lvl_cnt < HALF_CYC + 1) begin
                lvl_cnt <= lvl_cnt + 1;
            end
        end
    end

    // R2: each serial-clock level lasts HALF_CYC cycles
    a_r2_half_period: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && sclk_o != prev_sclk) |-> lvl_cnt == HALF_CYC);

    // R3: frame opens on a rising serial-clock edge
    a_r3_start_on_rise: assert property (@(posedge clk) disable iff (rst)
        $fell(strb_n_o) |-> $rose(sclk_o));

    // R5: frame closes on a rising edge after a fixed length
    a_r5_end_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(strb_n_o) |-> $rose(sclk_o));

    a_r5_frame_length: assert property (@(posedge clk) disable iff (rst)
        $rose(strb_n_o) |-> low_cnt == FRAME_CYC);

    // R4: data holds between rising edges
    a_r4_data_stable: assert property (@(posedge clk) disable iff (rst)
        (sdata_oe && $past(sdata_oe) && !$rose(sclk_o)) |-> $stable(sdata_o));

    // R6: data driven only with a low driven strobe
    a_r6_data_framed: assert property (@(posedge clk) disable iff (rst)
        sdata_oe |-> (strb_oe && !strb_n_o));

    // R7: free-running clock always driven
    a_r7_cont_clock: assert property (@(posedge clk) disable iff (rst)
        cont_mode |-> sclk_oe);

    // R8: gated clock released outside frames
    a_r8_gated_release: assert property (@(posedge clk) disable iff (rst)
        (!cont_mode && strb_n_o) |-> !sclk_oe);

endmodule

bind serial_result_tx sertx_sva #(.HALF_CYC(HALF_CYC)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .cont_mode (cont_mode),
    .sclk_o    (sclk_o),
    .sclk_oe   (sclk_oe),
    .strb_n_o  (strb_n_o),
    .strb_oe   (strb_oe),
    .sdata_o   (sdata_o),
    .sdata_oe  (sdata_oe)
);

// File: tb/serial_result_tx_tb.sv
`timescale 1ns/1ps
module serial_result_tx_tb;

    localparam int HALF = 2;
    localparam int NBIT = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cont_mode = 1'b0;
    logic load = 1'b0;
    logic [NBIT-1:0] result = '0;
    logic sclk_o, sclk_oe, strb_n_o, strb_oe, sdata_o, sdata_oe;

    int errors = 0;
    int checks = 0;
    bit timed_out = 0;

    always #2 clk = ~clk;

    serial_result_tx #(.HALF_CYC(HALF)) u_dut (
        .clk(clk), .rst(rst), .cont_mode(cont_mode), .load(load), .result(result),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .strb_n_o(strb_n_o), .strb_oe(strb_oe),
        .sdata_o(sdata_o), .sdata_oe(sdata_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int k;
    bit m_act, m_pend;
    int m_idx;
    logic [NBIT-1:0] m_hold, m_word;

    always @(posedge clk) begin
        if (rst) begin
            k = 0; m_act = 0; m_pend = 0; m_idx = 0; m_hold = '0; m_word = '0;
        end else begin
            k++;
            if (k % (2*HALF) == HALF) begin
                if (m_act) begin
                    if (m_idx == 0) m_act = 0;
                    else m_idx--;
                end else if (m_pend) begin
                    m_act = 1; m_idx = NBIT-1; m_word = m_hold; m_pend = 0;
                end
            end
            if (load) begin
                m_hold = result; m_pend = 1;
            end
        end
    end

    // expected received words
    int exp_q[$];
    string tag_q[$];

    bit prev_low = 0, prev_sclk = 0, seen_frame = 0;
    int rx_bits = 0, gap = 0, last_gap = 0;
    logic [NBIT-1:0] rx_word = '0;

    always @(negedge clk) begin
        if (!rst) begin
            bit frame_low;
            // per-cycle comparison with the model
            chk(sclk_o == ((k / HALF) % 2), "R2 sclk level", sclk_o, (k / HALF) % 2);
            chk(strb_n_o == !m_act && strb_oe == m_act, "R5 strobe", {strb_oe, strb_n_o}, {m_act, !m_act});
            chk(sdata_oe == m_act, "R6 sdata_oe", sdata_oe, m_act);
            if (m_act) chk(sdata_o == m_word[m_idx], "R4 sdata bit", sdata_o, m_word[m_idx]);
            if (cont_mode) chk(sclk_oe == 1'b1, "R7 sclk_oe", sclk_oe, 1);
            else chk(sclk_oe == m_act, "R8 sclk_oe", sclk_oe, m_act);

            // serial receiver
            frame_low = strb_oe && !strb_n_o;
            if (frame_low && !prev_low) begin
                chk(sclk_o == 1'b1, "R3 strobe before first fall", sclk_o, 1);
                if (seen_frame) chk(gap >= 2*HALF, "R5 idle gap", gap, 2*HALF);
                last_gap = gap;
                rx_bits = 0; rx_word = '0; seen_frame = 1;
            end
            if (frame_low && prev_sclk && !sclk_o) begin
                rx_word = {rx_word[NBIT-2:0], sdata_o};
                rx_bits++;
            end
            if (!frame_low && prev_low) begin
                chk(rx_bits == NBIT, "R5 falls per frame", rx_bits, NBIT);
                if (exp_q.size() == 0) begin
                    chk(0, "R11 unexpected frame", rx_word, 0);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(rx_word == e[NBIT-1:0], t, rx_word, e);
                end
                gap = 0;
            end
            if (!frame_low) gap++;
            prev_low = frame_low;
            prev_sclk = sclk_o;
        end
    end

    task automatic do_load(input logic [NBIT-1:0] v);
        @(negedge clk); #1;
        result = v; load = 1'b1;
        @(negedge clk); #1;
        load = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(negedge clk); n++;
        end while ((m_act || m_pend) && n < 2000);
        repeat (3*HALF) @(negedge clk);
    endtask

    task automatic expect_word(input int v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic scenario();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(strb_n_o == 1 && strb_oe == 0 && sdata_oe == 0 && sclk_o == 0 && sclk_oe == 0,
            "R1 reset outputs", {strb_n_o, strb_oe, sdata_oe, sclk_o, sclk_oe}, 5'b10000);
        @(negedge clk); #1; rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(strb_n_o == 1 && sdata_oe == 0, "R1 idle after reset", {strb_n_o, sdata_oe}, 2'b10);

        // gated mode: extremes of the two's complement range
        expect_word(14'h2000, "R11 most negative");
        do_load(14'h2000);
        wait_idle();
        expect_word(14'h1FFF, "R11 most positive");
        do_load(14'h1FFF);
        wait_idle();

        // R9 and R10: load during frame, then overwrite before start
        expect_word(14'h0ACE, "R9 first word");
        do_load(14'h0ACE);
        while (!m_act) @(negedge clk);
        repeat (10) @(negedge clk);
        do_load(14'h1234);
        do_load(14'h3C5A);
        expect_word(14'h3C5A, "R10 latest load wins");
        wait_idle();
        chk(last_gap == 2*HALF, "R9 deferred start one period after end", last_gap, 2*HALF);

        // R7: continuous mode
        @(negedge clk); #1; cont_mode = 1'b1;
        repeat (12) @(negedge clk);
        expect_word(14'h2A55, "R11 pattern 2A55");
        do_load(14'h2A55);
        wait_idle();
        expect_word(14'h0001, "R4 lsb only");
        do_load(14'h0001);
        wait_idle();

        // back to gated mode, clock released while idle
        @(negedge clk); #1; cont_mode = 1'b0;
        repeat (20) @(negedge clk);
        chk(sclk_oe == 0, "R8 gated idle release", sclk_oe, 0);
        chk(exp_q.size() == 0, "R11 all words received", exp_q.size(), 0);
    endtask

    initial begin
        fork
            scenario();
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        if (timed_out) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule